// File: doc/BRIEF.md
# Multicast Hash Filter

This block decides, for each received frame whose destination address is a group address, whether the frame is kept or discarded. The six destination address bytes arrive one per valid cycle after a start-of-frame strobe. While they stream in, the block folds them into an Ethernet CRC-32. When the sixth byte has been taken, the top six bits of that CRC index a 64-bit hash table, and the block registers a verdict.

The table is held in four 16-bit words that the host writes and reads back by word select. Two control inputs bypass the table. One accepts every frame. The other accepts every group-addressed frame. Frames whose destination is not a group address are marked as not group, and this block leaves their fate to the rest of the receive path.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all four table words read back as 0x0000, and `dec_valid_o`, `dec_group_o`, `dec_accept_o` and `hash_idx_o` are 0.
- R2: A write with `tbl_we_i` high stores `tbl_wdata_i` into the word chosen by `tbl_sel_i`. From the next cycle `tbl_rdata_o` shows that value while `tbl_sel_i` selects the word.
- R3: `hash_idx_o` holds bits 31:26 of a CRC-32 taken over the six address bytes. The CRC uses polynomial 0x04C11DB7 and starts from 0xFFFFFFFF. Each byte is fed bit 0 first, and the register shifts toward bit 31. No final inversion is applied.
- R4: The hash index addresses the table as follows. Index bits 5:4 select the word, and index bits 3:0 select the bit within that word. A group frame whose selected bit is 1 is accepted (`dec_accept_o`=1).
- R5: A group frame whose selected table bit is 0 is dropped (`dec_accept_o`=0) while both override inputs are low.
- R6: A group frame is accepted whatever the table holds if `rx_all_i` is high in the cycle of the sixth address byte.
- R7: A group frame is accepted whatever the table holds if `rx_all_mcast_i` is high in the cycle of the sixth address byte.
- R8: A frame is a group frame when bit 0 of its first address byte is 1. For any other frame, `dec_group_o`=0 and `dec_accept_o`=0, even with an override set.
- R9: `dec_valid_o` is high for exactly one cycle, the cycle after the sixth address byte is taken. The verdict outputs then hold until the next `sof_i`, which clears them to 0.
- R10: `sof_i` restarts the CRC and the byte count. A byte presented in the same cycle as `sof_i` is the first address byte, and bytes of an abandoned partial address have no effect on the result.
- R11: A table write in the same cycle as the sixth address byte does not affect that frame's verdict. The lookup uses the table contents from before the write.
- R12: Bytes after the sixth, up to the next `sof_i`, are ignored and raise no further `dec_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start of a new frame; restarts the address state |
| da_valid_i | input | 1 | `da_byte_i` carries a destination address byte |
| da_byte_i | input | 8 | Address byte, first byte first |
| rx_all_i | input | 1 | Accept every frame |
| rx_all_mcast_i | input | 1 | Accept every group-addressed frame |
| tbl_we_i | input | 1 | Table word write strobe |
| tbl_sel_i | input | 2 | Table word select for write and read |
| tbl_wdata_i | input | 16 | Table word write data |
| tbl_rdata_o | output | 16 | Selected table word |
| dec_valid_o | output | 1 | One-cycle strobe: verdict ready |
| dec_group_o | output | 1 | Frame carries a group address |
| dec_accept_o | output | 1 | Group frame accepted |
| hash_idx_o | output | 6 | Hash index of the current frame |

## Verification
The checks assume that every frame starts with a `sof_i` pulse and that at least six address bytes follow before the next `sof_i`. Under that assumption two verdict strobes can never fall in adjacent cycles. They also assume that the override inputs and the table are steady in the cycle of the sixth byte, apart from the deliberate collision case. The stimulus raises `sof_i` together with the first byte of each frame. It abandons an address only by issuing a fresh `sof_i`, and it changes the overrides and the table only between frames, except in the single test that aims a write at the sixth byte.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // fold one byte, bit 0 first, non-reflected register
  function automatic logic [31:0] crc_fold_byte(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] r;
    logic        fb;
    r = crc;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ b[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             last_o,
  output logic             group_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

  logic [31:0]      crc_q, crc_base, crc_d;
  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic             grp_q, take;

  always_comb begin
    crc_base = sof_i ? CRC_INIT : crc_q;
    cnt_base = sof_i ? '0 : cnt_q;
    take     = byte_valid_i && (cnt_base < CNT_W'(ADDR_BYTES));
    crc_d    = take ? crc_fold_byte(crc_base, byte_i) : crc_base;
    last_o   = take && (cnt_base == CNT_W'(ADDR_BYTES - 1));
    group_o  = (take && cnt_base == '0) ? byte_i[0] : (sof_i ? 1'b0 : grp_q);
    idx_o    = crc_d[31 -: IDX_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= CRC_INIT;
      cnt_q <= '0;
      grp_q <= 1'b0;
    end else begin
      crc_q <= crc_d;
      cnt_q <= cnt_base + CNT_W'(take);
      grp_q <= group_o;
    end
  end
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned SEL_W = $clog2(WORDS),
  localparam int unsigned IDX_W = $clog2(WORDS * WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              hit_o
);
  logic [WORDS*WORD_W-1:0] bits_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            bits_q[w*WORD_W +: WORD_W] <= '0;
      else if (we_i && sel_i == SEL_W'(w))    bits_q[w*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  // upper index bits pick the word, lower the bit: flat position equals index
  assign rdata_o = bits_q[sel_i*WORD_W +: WORD_W];
  assign hit_o   = bits_q[idx_i];
endmodule

// File: rtl/mhf_decision.sv
module mhf_decision #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             last_i,
  input  logic             group_i,
  input  logic             hit_i,
  input  logic             rx_all_i,
  input  logic             rx_all_mcast_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             valid_o,
  output logic             group_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o
);
  logic accept_d;
  assign accept_d = group_i && (rx_all_i || rx_all_mcast_i || hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      group_o  <= 1'b0;
      accept_o <= 1'b0;
      idx_o    <= '0;
    end else begin
      valid_o <= last_i;
      if (last_i) begin
        group_o  <= group_i;
        accept_o <= accept_d;
        idx_o    <= idx_i;
      end else if (sof_i) begin
        group_o  <= 1'b0;
        accept_o <= 1'b0;
        idx_o    <= '0;
      end
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned TBL_WORDS  = 4,
  parameter int unsigned TBL_WORD_W = 16,
  localparam int unsigned SEL_W = $clog2(TBL_WORDS),
  localparam int unsigned IDX_W = $clog2(TBL_WORDS * TBL_WORD_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sof_i,
  input  logic                  da_valid_i,
  input  logic [7:0]            da_byte_i,
  input  logic                  rx_all_i,
  input  logic                  rx_all_mcast_i,
  input  logic                  tbl_we_i,
  input  logic [SEL_W-1:0]      tbl_sel_i,
  input  logic [TBL_WORD_W-1:0] tbl_wdata_i,
  output logic [TBL_WORD_W-1:0] tbl_rdata_o,
  output logic                  dec_valid_o,
  output logic                  dec_group_o,
  output logic                  dec_accept_o,
  output logic [IDX_W-1:0]      hash_idx_o
);
  logic             last, group, hit;
  logic [IDX_W-1:0] idx;

  mhf_crc_engine #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_crc (
    .clk_i, .rst_ni, .sof_i,
    .byte_valid_i (da_valid_i),
    .byte_i       (da_byte_i),
    .last_o       (last),
    .group_o      (group),
    .idx_o        (idx)
  );

  mhf_hash_table #(.WORDS(TBL_WORDS), .WORD_W(TBL_WORD_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i    (tbl_we_i),
    .sel_i   (tbl_sel_i),
    .wdata_i (tbl_wdata_i),
    .rdata_o (tbl_rdata_o),
    .idx_i   (idx),
    .hit_o   (hit)
  );

  mhf_decision #(.IDX_W(IDX_W)) u_dec (
    .clk_i, .rst_ni, .sof_i,
    .last_i         (last),
    .group_i        (group),
    .hit_i          (hit),
    .rx_all_i       (rx_all_i),
    .rx_all_mcast_i (rx_all_mcast_i),
    .idx_i          (idx),
    .valid_o        (dec_valid_o),
    .group_o        (dec_group_o),
    .accept_o       (dec_accept_o),
    .idx_o          (hash_idx_o)
  );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sof_i,
  input logic              da_valid_i,
  input logic              rx_all_i,
  input logic              rx_all_mcast_i,
  input logic              tbl_we_i,
  input logic [SEL_W-1:0]  tbl_sel_i,
  input logic [WORD_W-1:0] tbl_wdata_i,
  input logic [WORD_W-1:0] tbl_rdata_o,
  input logic              dec_valid_o,
  input logic              dec_group_o,
  input logic              dec_accept_o
);
  logic              we_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= 1'b0;
      sel_q <= '0;
      wd_q  <= '0;
    end else begin
      we_q  <= tbl_we_i;
      sel_q <= tbl_sel_i;
      wd_q  <= tbl_wdata_i;
    end
  end

  // R2
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && tbl_sel_i == sel_q) |-> tbl_rdata_o == wd_q);

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);

  // R9
  verdict_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_valid_o && !$past(sof_i)) |-> ($stable(dec_accept_o) && $stable(dec_group_o)));

  // R12
  valid_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(da_valid_i));

  // R8
  nongroup_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_group_o |-> !dec_accept_o);

  // R6 R7
  override_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_group_o && ($past(rx_all_i) || $past(rx_all_mcast_i))) |-> dec_accept_o);
endmodule

bind mcast_hash_filter mhf_checker #(.SEL_W(SEL_W), .WORD_W(TBL_WORD_W)) u_chk (
  .clk_i, .rst_ni, .sof_i, .da_valid_i, .rx_all_i, .rx_all_mcast_i,
  .tbl_we_i, .tbl_sel_i, .tbl_wdata_i, .tbl_rdata_o,
  .dec_valid_o, .dec_group_o, .dec_accept_o
);

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sof = 0, dval = 0, rx_all = 0, rx_mc = 0, we = 0;
  logic [7:0]  dbyte = '0;
  logic [1:0]  sel = '0;
  logic [15:0] wdata = '0, rdata;
  logic        dvalid, dgrp, dacc;
  logic [5:0]  didx;

  int checks = 0, failures = 0;
  logic [15:0] tbl_m [4];

  typedef struct {
    logic       grp;
    logic       acc;
    logic [5:0] idx;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  mcast_hash_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .da_valid_i(dval), .da_byte_i(dbyte),
    .rx_all_i(rx_all), .rx_all_mcast_i(rx_mc), .tbl_we_i(we), .tbl_sel_i(sel),
    .tbl_wdata_i(wdata), .tbl_rdata_o(rdata), .dec_valid_o(dvalid),
    .dec_group_o(dgrp), .dec_accept_o(dacc), .hash_idx_o(didx)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic b, fb;
      b  = da[40 - 8*(i/8) + (i%8)];
      fb = r[31] ^ b;
      r  = {r[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return r[31:26];
  endfunction

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    we = 1; sel = s; wdata = d;
    @(posedge clk); #1;
    we = 0;
    tbl_m[s] = d;
  endtask

  task automatic set_bit(input logic [5:0] ix, input bit v);
    logic [15:0] w;
    w = tbl_m[ix[5:4]];
    w[ix[3:0]] = v;
    wr(ix[5:4], w);
  endtask

  // drives six address bytes plus extra; optional write on the sixth byte
  task automatic send(input logic [47:0] da, input int extra, input bit wr_last,
                      input logic [1:0] ws, input logic [15:0] wd, input string req);
    exp_t e;
    e.idx = ref_idx(da);
    e.grp = da[40];
    e.acc = e.grp && (rx_all || rx_mc || tbl_m[e.idx[5:4]][e.idx[3:0]]);
    e.req = req;
    sb.push_back(e);
    for (int k = 0; k < 6 + extra; k++) begin
      sof   = (k == 0);
      dval  = 1;
      dbyte = (k < 6) ? da[47 - 8*k -: 8] : 8'(8'hA0 + k);
      if (wr_last && k == 5) begin we = 1; sel = ws; wdata = wd; end
      @(posedge clk); #1;
      we = 0;
    end
    sof = 0; dval = 0;
    if (wr_last) tbl_m[ws] = wd;
    @(posedge clk); #1;
  endtask

  // monitor: pops expected verdicts as strobes appear
  always @(negedge clk) begin
    if (rst_n && dvalid) begin
      if (sb.size() == 0) begin
        check(0, "R12 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(dgrp == e.grp, {e.req, " R8 group"}, dgrp, e.grp);
        check(dacc == e.acc, {e.req, " accept"}, dacc, e.acc);
        check(didx == e.idx, {"R3 index ", e.req}, didx, e.idx);
      end
    end
  end

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [47:0] mc_a, uc_a;
    logic [5:0]  ia;
    for (int i = 0; i < 4; i++) tbl_m[i] = '0;
    mc_a = 48'h01005E000001;
    uc_a = 48'h001122334455;
    ia   = ref_idx(mc_a);
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      @(negedge clk);
      check(rdata == 16'h0, "R1 table reset", rdata, 0);
      @(posedge clk); #1;
    end
    check({dvalid, dgrp, dacc, didx} == '0, "R1 outputs reset", {dvalid, dgrp, dacc, didx}, 0);

    // R2 write and read back
    wr(2'd2, 16'hA5C3);
    sel = 2'd2; @(negedge clk);
    check(rdata == 16'hA5C3, "R2 readback", rdata, 16'hA5C3);
    sel = 2'd1; @(negedge clk);
    check(rdata == 16'h0, "R2 other word", rdata, 0);
    @(posedge clk); #1;
    wr(2'd2, 16'h0);

    // R4 hit, R5 miss
    set_bit(ia, 1);
    send(mc_a, 0, 0, 0, 0, "R4");
    // R9 hold then clear on sof
    repeat (3) @(negedge clk);
    check(dacc == 1 && dgrp == 1, "R9 hold", {dgrp, dacc}, 2'b11);
    @(posedge clk); #1;
    sof = 1; @(posedge clk); #1; sof = 0;
    @(negedge clk);
    check(dacc == 0 && dgrp == 0, "R9 clear on sof", {dgrp, dacc}, 0);
    @(posedge clk); #1;
    set_bit(ia, 0);
    send(mc_a, 0, 0, 0, 0, "R5");

    // R6, R7 overrides
    rx_all = 1; send(mc_a, 0, 0, 0, 0, "R6"); rx_all = 0;
    rx_mc  = 1; send(mc_a, 0, 0, 0, 0, "R7"); rx_mc  = 0;

    // R8 non-group frames
    rx_all = 1; send(uc_a, 0, 0, 0, 0, "R8 override"); rx_all = 0;
    set_bit(ref_idx(uc_a), 1);
    send(uc_a, 0, 0, 0, 0, "R8 table");

    // R10 abandoned partial address
    for (int k = 0; k < 3; k++) begin
      sof = (k == 0); dval = 1; dbyte = 8'hFF - 8'(k);
      @(posedge clk); #1;
    end
    sof = 0; dval = 0;
    set_bit(ia, 1);
    send(mc_a, 0, 0, 0, 0, "R10");

    // R12 trailing bytes ignored
    send(mc_a, 4, 0, 0, 0, "R12");

    // R11 write on sixth byte: old table used, new one on next frame
    send(mc_a, 0, 1, ia[5:4], tbl_m[ia[5:4]] & ~(16'h1 << ia[3:0]), "R11 old");
    send(mc_a, 0, 0, 0, 0, "R11 new");

    // R3 R4 R5 several addresses against a mixed table
    wr(0, 16'h8421); wr(1, 16'hF00F); wr(2, 16'h3C3C); wr(3, 16'h5A5A);
    for (int n = 0; n < 10; n++) begin
      logic [47:0] a;
      a = {8'(8'h01 + 2*n), 8'h00, 8'h5E, 8'(n*37), 8'(n*11 + 3), 8'(8'hC0 ^ n)};
      send(a, 0, 0, 0, 0, "R4 R5 sweep");
    end

    repeat (4) @(posedge clk);
    check(sb.size() == 0, "R9 all verdicts seen", sb.size(), 0);
    finish_up();
  end
endmodule